// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block takes two IEEE 754 binary64 operands and reports how they relate as three condition flags: carry, parity and zero. The encoding is the one that scalar floating-point compares have long used. Greater-than clears all three flags. Less-than sets only carry. Equality sets only zero. An unordered result, where at least one operand is a NaN, sets all three. The same outcome also appears as a 3-bit coprocessor-style condition code. Software-visible branching such as "carry clear and zero clear" therefore selects greater-than and nothing else.

The operands are treated as sign-magnitude values, not as raw unsigned integers. Inside one sign, the 63 magnitude bits order correctly as unsigned integers. For two negative operands that order is reversed. A denormals-are-zero input can make subnormal inputs count as exactly zero. A mode input sets whether any NaN raises the invalid-operation output, or only a signaling NaN does. A result is captured one clock after an input strobe and then held until the next one.

Top module: `fcmp_flag_unit`

## Requirements
- R1: If either operand has an all-ones exponent and a nonzero fraction, the result is unordered and carryFlag, parityFlag and zeroFlag are all 1.
- R2: For ordered operands parityFlag is 0, zeroFlag is 1 only for equal values and carryFlag is 1 only when opA is less than opB. When opA is greater than opB, all three flags are 0.
- R3: Ordering follows the values in sign-magnitude form. A negative value is below every positive value. Between two negatives, the larger magnitude pattern is the smaller value (for example -2.0 below -1.0).
- R4: With dazEn low, subnormals compare by their true values, so 0x123 against 0x124 gives carryFlag 1 and zeroFlag 0.
- R5: With dazEn high, an operand with a zero exponent and a nonzero fraction counts as a zero of the same sign, so a subnormal equals either zero.
- R6: +0.0 and -0.0 compare equal: zeroFlag 1, carryFlag 0, parityFlag 0.
- R7: Infinities are ordered values. +inf is above the largest finite value, -inf is below every finite value, and two equal infinities set zeroFlag.
- R8: A NaN is quiet when fraction bit 51 is set and signaling when that bit is clear. With sigMode low, invalidOp is 1 only if an operand is a signaling NaN. With sigMode high, invalidOp is 1 if either operand is any NaN. Ordered compares give invalidOp 0.
- R9: condCode[0] equals carryFlag, condCode[1] equals parityFlag and condCode[2] equals zeroFlag for every outcome.
- R10: After reset, all outputs are 0. outValid is 1 exactly in the cycle after a cycle with inValid 1. The flags, condCode and invalidOp change only on such a capture and keep their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands valid this cycle |
| opA | input | 64 | First operand, binary64 |
| opB | input | 64 | Second operand, binary64 |
| dazEn | input | 1 | Treat subnormal inputs as zero |
| sigMode | input | 1 | 1: any NaN is invalid; 0: only signaling NaN |
| outValid | output | 1 | Result captured on the previous edge |
| carryFlag | output | 1 | Less-than or unordered |
| parityFlag | output | 1 | Unordered |
| zeroFlag | output | 1 | Equal or unordered |
| condCode | output | 3 | {C3, C2, C0} = {zero, parity, carry} |
| invalidOp | output | 1 | Invalid-operation indication |

## Verification
The hardest cases to reach from the ports are the boundaries where the raw bit patterns and the real values disagree. These are two negative operands, a pair of signed zeros, subnormals under each setting of dazEn, and the one fraction bit that separates a quiet NaN from a signaling NaN. The stimulus aims at each of these with chosen bit patterns, including the largest finite value against infinity. The reference model decides each outcome from the values the patterns hold, not from an integer compare. Back-to-back strobes and idle gaps are mixed in between, so that the hold behaviour is also observed in the cycles where nothing is captured.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  // Registered compare outcome, packed as {C3, C2, C0}
  typedef struct packed {
    logic zf;
    logic pf;
    logic cf;
  } cmpFlags_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;     // load the result register this edge
    logic trapAnyNan;  // quiet NaNs also raise invalid
  } ctrlStrobes_t;

  localparam cmpFlags_t FLAGS_UNORD = '{zf: 1'b1, pf: 1'b1, cf: 1'b1};

endpackage

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         sigMode,
  output ctrlStrobes_t ctrl,
  output logic         outValid
);

  always_comb begin
    ctrl.capture    = inValid;
    ctrl.trapAnyNan = sigMode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R10
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctrlStrobes_t              ctrl,
  input  logic [EXP_W+FRAC_W:0]     opA,
  input  logic [EXP_W+FRAC_W:0]     opB,
  input  logic                      dazEn,
  output cmpFlags_t                 flags,
  output logic                      invalidOp
);

  localparam int DATA_W = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = EXP_W + FRAC_W;
  localparam int N_OPS  = 2;

  logic [DATA_W-1:0] opArr   [N_OPS];
  logic [MAG_W-1:0]  magArr  [N_OPS];
  logic [N_OPS-1:0]  sgnVec;
  logic [N_OPS-1:0]  nanVec;
  logic [N_OPS-1:0]  snanVec;

  assign opArr[0] = opA;
  assign opArr[1] = opB;

  // Per-operand classification and optional subnormal flush
  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_class
    logic expOnes;
    logic expZero;
    logic fracNz;
    logic isSub;
    assign expOnes     = &opArr[gi][DATA_W-2 -: EXP_W];
    assign expZero     = ~|opArr[gi][DATA_W-2 -: EXP_W];
    assign fracNz      = |opArr[gi][FRAC_W-1:0];
    assign isSub       = expZero & fracNz;
    assign nanVec[gi]  = expOnes & fracNz;
    assign snanVec[gi] = expOnes & fracNz & ~opArr[gi][FRAC_W-1];
    assign sgnVec[gi]  = opArr[gi][DATA_W-1];
    assign magArr[gi]  = (isSub && dazEn) ? '0 : opArr[gi][MAG_W-1:0];
  end

  // Sign-magnitude relation
  logic unordered;
  logic bothZero;
  logic magEq;
  logic magLt;
  logic isEqual;
  logic isLess;
  cmpFlags_t nextFlags;
  logic      nextInvalid;

  always_comb begin
    unordered = |nanVec;
    bothZero  = (magArr[0] == '0) && (magArr[1] == '0);
    magEq     = (magArr[0] == magArr[1]);
    magLt     = (magArr[0] <  magArr[1]);
    isEqual   = bothZero || ((sgnVec[0] == sgnVec[1]) && magEq);
    isLess    = 1'b0;
    if (!isEqual) begin
      unique case (sgnVec)
        2'b01:   isLess = 1'b1;             // opA negative, opB positive
        2'b10:   isLess = 1'b0;             // opA positive, opB negative
        2'b00:   isLess = magLt;            // both positive
        default: isLess = !magLt && !magEq; // both negative: order flips
      endcase
    end
    if (unordered) begin
      nextFlags = FLAGS_UNORD;
    end else begin
      nextFlags.zf = isEqual;
      nextFlags.pf = 1'b0;
      nextFlags.cf = isLess;
    end
    nextInvalid = ctrl.trapAnyNan ? unordered : |snanVec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags     <= '0;
      invalidOp <= 1'b0;
    end else if (ctrl.capture) begin
      flags     <= nextFlags;
      invalidOp <= nextInvalid;
    end
  end

  // R1
  nan_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.capture && (&opB[DATA_W-2 -: EXP_W]) && (|opB[FRAC_W-1:0]))
      |=> (flags.pf && flags.zf && flags.cf));

  // R1
  parity_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags.pf |-> (flags.zf && flags.cf));

  // R2
  ordered_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags.pf |-> !(flags.zf && flags.cf));

  // R8
  invalid_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalidOp |-> flags.pf);

  // R10
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.capture |=> ($stable(flags) && $stable(invalidOp)));

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  input  logic                  dazEn,
  input  logic                  sigMode,
  output logic                  outValid,
  output logic                  carryFlag,
  output logic                  parityFlag,
  output logic                  zeroFlag,
  output logic [2:0]            condCode,
  output logic                  invalidOp
);

  ctrlStrobes_t ctrl;
  cmpFlags_t    flags;

  fcmp_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .sigMode  (sigMode),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  fcmp_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .opA       (opA),
    .opB       (opB),
    .dazEn     (dazEn),
    .flags     (flags),
    .invalidOp (invalidOp)
  );

  assign carryFlag  = flags.cf;
  assign parityFlag = flags.pf;
  assign zeroFlag   = flags.zf;
  assign condCode   = flags;   // R9: {C3,C2,C0}

endmodule

// File: tb/fcmp_flag_unit_tb_top.sv
module fcmp_flag_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        dazEn = 1'b0;
  logic        sigMode = 1'b0;
  logic        outValid, carryFlag, parityFlag, zeroFlag, invalidOp;
  logic [2:0]  condCode;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  fcmp_flag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opA(opA), .opB(opB),
    .dazEn(dazEn), .sigMode(sigMode), .outValid(outValid),
    .carryFlag(carryFlag), .parityFlag(parityFlag), .zeroFlag(zeroFlag),
    .condCode(condCode), .invalidOp(invalidOp)
  );

  localparam logic [63:0] P_ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] P_TWO  = 64'h4000000000000000;
  localparam logic [63:0] N_ONE  = 64'hBFF0000000000000;
  localparam logic [63:0] N_TWO  = 64'hC000000000000000;
  localparam logic [63:0] P_ZERO = 64'h0000000000000000;
  localparam logic [63:0] N_ZERO = 64'h8000000000000000;
  localparam logic [63:0] P_INF  = 64'h7FF0000000000000;
  localparam logic [63:0] N_INF  = 64'hFFF0000000000000;
  localparam logic [63:0] QNAN   = 64'h7FF8000000000000;
  localparam logic [63:0] SNAN   = 64'h7FF0000000000001;
  localparam logic [63:0] MAXF   = 64'h7FEFFFFFFFFFFFFF;
  localparam logic [63:0] SUB_A  = 64'h0000000000000123;
  localparam logic [63:0] SUB_B  = 64'h0000000000000124;
  localparam logic [63:0] NSUB   = 64'h8000000000000123;

  // Reference model: {zf,pf,cf} from the values the patterns stand for
  function automatic logic [3:0] refModel(input logic [63:0] a, input logic [63:0] b,
                                          input logic daz, input logic sig);
    logic nanA, nanB, sA, sB;
    logic [63:0] fa, fb;
    real ra, rb;
    nanA = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
    nanB = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
    sA   = nanA && !a[51];
    sB   = nanB && !b[51];
    if (nanA || nanB) return {sig ? 1'b1 : (sA || sB), 3'b111};
    fa = (daz && a[62:52] == 0) ? {a[63], 63'd0} : a;
    fb = (daz && b[62:52] == 0) ? {b[63], 63'd0} : b;
    ra = $bitstoreal(fa);
    rb = $bitstoreal(fb);
    if (ra == rb) return 4'b0100;
    if (ra <  rb) return 4'b0001;
    return 4'b0000;
  endfunction

  logic       eValid = 1'b0;
  logic [2:0] eCode  = '0;
  logic       eInv   = 1'b0;
  string      eTag   = "R10";
  string      curTag = "R10";

  always @(posedge clk) begin
    logic [3:0] r;
    if (!rst_n) begin
      eValid <= 1'b0; eCode <= '0; eInv <= 1'b0;
    end else begin
      eValid <= inValid;
      if (inValid) begin
        r = refModel(opA, opB, dazEn, sigMode);
        eCode <= r[2:0];
        eInv  <= r[3];
        eTag  <= curTag;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    string tag;
    tag = eValid ? eTag : "R10";
    total++;
    if (outValid !== eValid) begin
      bad++;
      $display("FAIL R10 outValid act=%b exp=%b", outValid, eValid);
    end
    if (condCode !== eCode || invalidOp !== eInv) begin
      bad++;
      $display("FAIL %s code/inv act=%b/%b exp=%b/%b", tag, condCode, invalidOp, eCode, eInv);
    end
    // R9: discrete flags mirror the condition code
    if ({zeroFlag, parityFlag, carryFlag} !== eCode) begin
      bad++;
      $display("FAIL R9 flags act=%b exp=%b", {zeroFlag, parityFlag, carryFlag}, eCode);
    end
  end

  task automatic send(input logic [63:0] a, input logic [63:0] b,
                      input logic daz, input logic sig, input string tag);
    @(negedge clk);
    opA = a; opB = b; dazEn = daz; sigMode = sig; inValid = 1'b1; curTag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = ~opA; opB = opB ^ 64'h5; // R10: changing data without a strobe
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    send(P_ONE,  P_TWO,  0, 0, "R2");
    send(P_TWO,  P_ONE,  0, 0, "R2");
    send(P_ONE,  P_ONE,  0, 0, "R2");
    idle(3);
    send(N_TWO,  N_ONE,  0, 0, "R3");
    send(N_ONE,  N_TWO,  0, 0, "R3");
    send(N_ONE,  P_ONE,  0, 0, "R3");
    send(P_ONE,  N_TWO,  0, 0, "R3");
    send(SUB_A,  SUB_B,  0, 0, "R4");
    send(SUB_B,  SUB_A,  0, 0, "R4");
    send(SUB_A,  P_ZERO, 0, 0, "R4");
    idle(2);
    send(SUB_A,  SUB_B,  1, 0, "R5");
    send(NSUB,   P_ZERO, 1, 0, "R5");
    send(SUB_A,  N_ZERO, 1, 0, "R5");
    send(P_ZERO, N_ZERO, 0, 0, "R6");
    send(N_ZERO, P_ZERO, 1, 0, "R6");
    send(P_INF,  MAXF,   0, 0, "R7");
    send(N_INF,  N_TWO,  0, 0, "R7");
    send(P_INF,  P_INF,  0, 0, "R7");
    send(N_INF,  N_INF,  0, 0, "R7");
    send(QNAN,   P_ONE,  0, 0, "R1");
    send(P_ONE,  SNAN,   0, 0, "R1");
    send(QNAN,   QNAN,   0, 0, "R8");
    send(QNAN,   P_ONE,  1, 1, "R8");
    send(SNAN,   P_ZERO, 0, 0, "R8");
    send(P_ONE,  P_TWO,  0, 1, "R8");
    idle(4);
    send(N_INF,  QNAN | 64'h8000000000000000, 0, 1, "R1");
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule